// File: doc/BRIEF.md
# MDIO Management Master

This block runs single management transactions on a two-wire PHY management link (a clock, MDC, and a bidirectional data line, MDIO). Software drives it through five 64-bit registers on a simple write strobe plus combinational read port. It can send the short framing used for 32 PHYs × 32 registers, or the extended framing in which a separate address frame selects a 16-bit register inside a device first.

To run a transaction, software first loads the data word and the clock setup, and turns the enable on. It then writes the command register and polls the pending flag until it clears. After a read, the returned word and its valid flag are in the read-data register. The block generates MDC from the system clock and drives MDIO through an output enable. During the turnaround and data portion of a read it lets go of the line and samples the PHY's answer on rising MDC edges.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Registers sit at offsets 0x00 (command), 0x08 (write data), 0x10 (read data), 0x18 (clock setup) and 0x20 (enable). After reset, clock setup reads 0x1001 (phase 1, preamble on, short framing), enable reads 0, and both data registers read 0.
- R2: A write to offset 0x00 while enabled and idle starts a frame. Bit 17 (pending) of both data registers reads 1 from then until the frame ends. The command fields are: register/device address in [4:0], PHY address in [12:8], operation in [17:16].
- R3: A command write that arrives while pending is 1 is ignored: the frame in flight goes on unchanged and no second frame follows.
- R4: While bit 0 of the enable register is 0, a command write starts nothing. MDC stays low and pending stays 0.
- R5: MDC is low when idle. During a frame, each MDC half period lasts phase+1 system clocks, where phase is clock setup bits [7:0]. The first half period of a frame is low.
- R6: A frame consists of the following, sent MSB first with each bit held for one MDC period and changed on the falling MDC edge:
  - 32 ones when clock setup bit 12 is 1;
  - start bits 01, or 00 when clock setup bit 24 is 1;
  - the operation bits;
  - the PHY address;
  - the register/device address;
  - turnaround 10;
  - write-data [15:0].
- R7: An operation with bit 1 set is a read. For a read, the output enable is 0 from the first turnaround bit to the end of the frame, and MDIO is sampled on each rising MDC edge.
- R8: After a read, read-data [15:0] holds the 16 sampled data bits, MSB first. Bit 16 (valid) is 1 only if the second turnaround bit was sampled as 0.
- R9: With extended framing, operation 00 sends an address frame whose 16 data bits are the write-data register. A later read sends the same header layout with its own operation.
- R10: A frame ends on a falling MDC edge, and pending clears once at that point. After a non-read frame, write-data bit 16 reads 1. A new launch clears both valid flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 64 | Register write value |
| bus_rdata | output | 64 | Register read value for bus_addr |
| mdio_i | input | 1 | Sampled MDIO line |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The serial behaviour is tried with several frame shapes:
- a short-framing write with preamble, which exposes start bits, field order and the turnaround pattern;
- a short-framing read without preamble at a slower phase, which shows the frame length and MDC timing depend on both settings;
- a read with no PHY answering, which separates a valid read from a failed one by the turnaround bit alone;
- an extended-framing address frame followed by a read at phase 0, which checks the 00 start bits and that the address word comes from the write-data register.

A command sent mid-frame and a command sent while disabled show whether launches are gated correctly.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter logic [7:0] RESET_PHASE = 8'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [63:0] bus_wdata,
  output logic [63:0] bus_rdata,
  input  logic        mdio_i,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam logic [5:0] OFF_CMD = 6'h00;
  localparam logic [5:0] OFF_WD  = 6'h08;
  localparam logic [5:0] OFF_RD  = 6'h10;
  localparam logic [5:0] OFF_CFG = 6'h18;
  localparam logic [5:0] OFF_EN  = 6'h20;

  logic [7:0]  phase_q;
  logic        pre_q, c45_q, en_q;
  logic [15:0] wdat_q, rdat_q;
  logic [11:0] cmd_q;
  logic        busy, mdc_q, is_read, rd_valid, wr_valid, ta_ok;
  logic [7:0]  div_q;
  logic [6:0]  rem_q;
  logic [63:0] sh_q;

  wire cmd_wr = bus_wr && bus_addr == OFF_CMD;
  wire launch = cmd_wr && en_q && !busy;
  wire tick   = busy && div_q == phase_q;
  wire rise   = tick && !mdc_q;
  wire fall   = tick && mdc_q;
  wire last   = fall && rem_q == 7'd1;
  wire [31:0] frame = {c45_q ? 2'b00 : 2'b01, bus_wdata[17:16], bus_wdata[12:8],
                       bus_wdata[4:0], bus_wdata[17] ? 2'b11 : 2'b10, wdat_q};
  wire unused_bits = ^{bus_wdata[63:25], bus_wdata[23:18]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= RESET_PHASE;
      pre_q   <= 1'b1;
      c45_q   <= 1'b0;
      en_q    <= 1'b0;
      wdat_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFF_WD:  wdat_q <= bus_wdata[15:0];
        OFF_CFG: begin
          phase_q <= bus_wdata[7:0];
          pre_q   <= bus_wdata[12];
          c45_q   <= bus_wdata[24];
        end
        OFF_EN:  en_q <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      mdc_q    <= 1'b0;
      div_q    <= '0;
      rem_q    <= '0;
      sh_q     <= '0;
      is_read  <= 1'b0;
      cmd_q    <= '0;
      rdat_q   <= '0;
      rd_valid <= 1'b0;
      wr_valid <= 1'b0;
      ta_ok    <= 1'b0;
    end else if (launch) begin
      busy     <= 1'b1;
      mdc_q    <= 1'b0;
      div_q    <= '0;
      rem_q    <= pre_q ? 7'd64 : 7'd32;
      sh_q     <= pre_q ? {32'hFFFF_FFFF, frame} : {frame, 32'h0};
      is_read  <= bus_wdata[17];
      cmd_q    <= {bus_wdata[17:16], bus_wdata[12:8], bus_wdata[4:0]};
      rd_valid <= 1'b0;
      wr_valid <= 1'b0;
      ta_ok    <= 1'b0;
    end else if (busy) begin
      if (tick) begin
        div_q <= '0;
        mdc_q <= ~mdc_q;
      end else begin
        div_q <= div_q + 8'd1;
      end
      if (rise && is_read && rem_q == 7'd17) ta_ok <= ~mdio_i;
      if (rise && is_read && rem_q <= 7'd16) rdat_q <= {rdat_q[14:0], mdio_i};
      if (last) begin
        busy     <= 1'b0;
        rd_valid <= is_read & ta_ok;
        wr_valid <= ~is_read;
      end else if (fall) begin
        rem_q <= rem_q - 7'd1;
        sh_q  <= {sh_q[62:0], 1'b0};
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_oe = busy && !(is_read && rem_q <= 7'd18);
  assign mdio_o  = mdio_oe & sh_q[63];

  always_comb begin
    case (bus_addr)
      OFF_CMD: bus_rdata = {46'b0, cmd_q[11:10], 3'b0, cmd_q[9:5], 3'b0, cmd_q[4:0]};
      OFF_WD:  bus_rdata = {46'b0, busy, wr_valid, wdat_q};
      OFF_RD:  bus_rdata = {46'b0, busy, rd_valid, rdat_q};
      OFF_CFG: bus_rdata = {39'b0, c45_q, 11'b0, pre_q, 4'b0, phase_q};
      OFF_EN:  bus_rdata = {63'b0, en_q};
      default: bus_rdata = {63'b0, unused_bits & 1'b0};
    endcase
  end
endmodule

module mdio_mgmt_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [5:0] bus_addr,
  input logic       mdc,
  input logic       mdio_oe,
  input logic       busy,
  input logic       en_q,
  input logic       is_read,
  input logic [7:0] phase_q
);
  logic [8:0] high_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) high_cnt <= '0;
    else if (mdc) high_cnt <= high_cnt + 9'd1;
    else high_cnt <= '0;
  end

  wire cmd_wr = bus_wr && bus_addr == 6'h00;

  a_r2_launch_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && en_q && !busy |=> busy);
  a_r3_busy_cmd_keeps_frame: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && busy && !(mdc && phase_q == 8'd0) |=> busy && $stable(is_read));
  a_r4_disabled_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !en_q && !busy |=> !busy);
  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  a_r5_high_half: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> high_cnt == ({1'b0, phase_q} + 9'd1));
  a_r7_oe_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);
  a_r10_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $fell(mdc));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .mdc(mdc), .mdio_oe(mdio_oe), .busy(busy), .en_q(en_q),
  .is_read(is_read), .phase_q(phase_q)
);

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, bus_wr, mdio_i, mdc, mdio_o, mdio_oe;
  logic [5:0]  bus_addr;
  logic [63:0] bus_wdata, bus_rdata;

  mdio_mgmt_master uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  int checks = 0, errors = 0, cyc = 0;

  bit m_busy, m_mdc, m_read, m_pre, m_c45, m_en;
  int m_div, m_idx, m_n, m_phase;
  logic [63:0] m_bits;
  logic [15:0] m_wdat;
  logic [31:0] m_frame;
  logic        ph_ta;
  logic [15:0] ph_data;
  logic [17:0] resp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_mdc = 0; m_read = 0; m_pre = 1; m_c45 = 0; m_en = 0;
      m_div = 0; m_idx = 0; m_n = 0; m_phase = 1; m_wdat = '0; m_bits = '0;
    end else begin
      if (!m_busy) begin
        if (bus_wr && bus_addr == 6'h00 && m_en) begin
          m_frame = {m_c45 ? 2'b00 : 2'b01, bus_wdata[17:16], bus_wdata[12:8],
                     bus_wdata[4:0], 2'b10, m_wdat};
          m_bits = m_pre ? {32'hFFFF_FFFF, m_frame} : {m_frame, 32'h0};
          m_n = m_pre ? 64 : 32;
          m_read = bus_wdata[17];
          m_busy = 1; m_mdc = 0; m_div = 0; m_idx = 0;
        end
      end else if (m_div == m_phase) begin
        m_div = 0;
        if (!m_mdc) m_mdc = 1;
        else begin
          m_mdc = 0;
          if (m_idx == m_n - 1) m_busy = 0;
          else m_idx++;
        end
      end else m_div++;
      if (bus_wr) begin
        if (bus_addr == 6'h08) m_wdat = bus_wdata[15:0];
        if (bus_addr == 6'h18) begin
          m_phase = int'(bus_wdata[7:0]); m_pre = bus_wdata[12]; m_c45 = bus_wdata[24];
        end
        if (bus_addr == 6'h20) m_en = bus_wdata[0];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_oe;
      exp_oe = m_busy && !(m_read && (m_n - m_idx) <= 18);
      checks++;
      if (mdc !== m_mdc) begin
        errors++; $display("FAIL R5 mdc act=%b exp=%b cyc=%0d", mdc, m_mdc, cyc);
      end else if (mdio_oe !== exp_oe) begin
        errors++; $display("FAIL R7 mdio_oe act=%b exp=%b cyc=%0d", mdio_oe, exp_oe, cyc);
      end else if (exp_oe && mdio_o !== m_bits[63 - m_idx]) begin
        errors++; $display("FAIL R6 R9 mdio_o bit %0d act=%b exp=%b", m_idx, mdio_o, m_bits[63 - m_idx]);
      end
      resp = {1'b1, ph_ta, ph_data};
      if (m_busy && m_read && (m_n - m_idx) <= 18) mdio_i = resp[17 - (18 - (m_n - m_idx))];
      else mdio_i = 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic wreg(input logic [5:0] a, input logic [63:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rreg(input logic [5:0] a, output logic [63:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++; $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done();
    int n = 0;
    while (m_busy && n < 20000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [63:0] cmd(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
    return {46'b0, op, 3'b0, phy, 3'b0, ra};
  endfunction

  logic [63:0] rv;

  initial begin
    rst_n = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; mdio_i = 1;
    ph_ta = 0; ph_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rreg(6'h18, rv); chk("R1 clock setup reset", rv, 64'h1001);
    rreg(6'h20, rv); chk("R1 enable reset", rv, 64'h0);
    rreg(6'h10, rv); chk("R1 read data reset", rv, 64'h0);

    wreg(6'h00, cmd(2'b01, 5'd3, 5'd5));
    repeat (40) @(negedge clk);
    rreg(6'h08, rv); chk("R4 pending while disabled", rv, 64'h0);
    chk("R4 mdc idle while disabled", {63'b0, mdc}, 64'h0);

    wreg(6'h20, 64'h1);
    wreg(6'h08, 64'hA5C3);
    wreg(6'h00, cmd(2'b01, 5'd3, 5'd5));
    repeat (10) @(negedge clk);
    rreg(6'h08, rv); chk("R2 pending in write data", rv[17], 1'b1);
    rreg(6'h10, rv); chk("R2 pending in read data", rv[17], 1'b1);
    wreg(6'h00, cmd(2'b10, 5'd9, 5'd1));
    wait_done();
    rreg(6'h10, rv); chk("R3 ignored read left no data", rv, 64'h0);
    rreg(6'h08, rv); chk("R10 write complete flags", rv, 64'h1A5C3);

    wreg(6'h18, 64'h0002);
    ph_ta = 0; ph_data = 16'h1234;
    wreg(6'h00, cmd(2'b10, 5'd1, 5'd2));
    wait_done();
    rreg(6'h10, rv); chk("R8 R7 read data good", rv, 64'h11234);

    ph_ta = 1; ph_data = 16'hFFFF;
    wreg(6'h00, cmd(2'b10, 5'd1, 5'd2));
    wait_done();
    rreg(6'h10, rv); chk("R8 read with no answer", rv, 64'h0FFFF);

    wreg(6'h18, 64'h0100_1000);
    wreg(6'h08, 64'hBEEF);
    wreg(6'h00, cmd(2'b00, 5'd7, 5'd3));
    wait_done();
    rreg(6'h08, rv); chk("R9 address frame done", rv, 64'h1BEEF);
    ph_ta = 0; ph_data = 16'hCAFE;
    wreg(6'h00, cmd(2'b11, 5'd7, 5'd3));
    wait_done();
    rreg(6'h10, rv); chk("R8 R9 extended read", rv, 64'h1CAFE);
    rreg(6'h08, rv); chk("R10 write valid cleared by read", rv, 64'hBEEF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule